// File: doc/BRIEF.md
# Timer/Event Counter with Prescaler

This block is an up-counting timer with a reload value. It can measure time from the system clock, count transitions on an external pin, or measure how long that pin stays at a chosen level. A control register picks the operating mode, the divide ratio of a power-of-two clock prescaler, the pin polarity and a run bit. When the counter passes its all-ones value it takes the reload value again. It also emits a one-cycle interrupt request and flips a divided-frequency output.

Software reaches the block through a small two-address register port. Address 0 is the counter. A write there sets the reload value, and a read returns the live count. Address 1 is the control register. The external pin is asynchronous. It goes through a synchronizer chain before any edge or level decision. Routing of the interrupt request is left to the surrounding chip.

Top module: `tmr_evt_ctr`

## Requirements
- R1: After reset the counter, reload value and control register read as 0x00, and `irq` and `freq_out` are low.
- R2: A write to address 0 sets the reload value. Address 0 reads the live counter. If the write happens while the block is stopped, the counter takes the written value too. If it happens while running, the counter is left unchanged.
- R3: Control register layout: bits [2:0] prescaler select, bit 3 polarity, bit 4 run enable, bits [7:6] mode (00 stopped, 01 event count, 10 timer, 11 pulse width). Bit 5 always reads 0, and the other bits read back as written.
- R4: In timer mode with select value s, the counter advances by one every 2^s clock cycles (1/1 up to 1/128). Any control write restarts the prescaler, so the first advance comes 2^s cycles after that write.
- R5: In event mode the pin passes two synchronizer flops. With polarity 0 each low-to-high transition adds one. With polarity 1 each high-to-low transition adds one. The other direction is ignored.
- R6: In pulse-width mode the counter advances on prescaler ticks only while the synchronized pin is at the active level (high for polarity 0, low for polarity 1). When that level ends, the run enable bit clears by itself and counting stops.
- R7: An advance from 0xFF loads the reload value into the counter and raises `irq` for one cycle.
- R8: `freq_out` toggles on every overflow and changes at no other time.
- R9: With mode 00 or run enable 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 counter/reload, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_pin | input | 1 | Asynchronous external event / gate input |
| irq | output | 1 | One-cycle overflow interrupt request |
| freq_out | output | 1 | Divided-frequency output, flips per overflow |

## Verification
The hardest case to reach is the automatic clearing of the run bit in pulse-width mode. It needs a gate interval that first opens and then closes, seen through the synchronizer delay. The prescaler phase also has to be known so the count can be predicted. The stimulus first sets the pin to its inactive level and then writes the control register, which restarts the prescaler. It then holds the pin active for a number of cycles that is a multiple of the divide ratio, so the expected count does not depend on phase. The control register is read back only after the synchronizer has seen the closing edge. Overflow timing is made reachable by writing a reload value close to 0xFF while stopped.

// File: rtl/tec_pkg.sv
package tec_pkg;
   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_PULSE = 2'b11
   } tec_mode_e;
endpackage

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   generate
      for (genvar i = 0; i < DIV_W; i++) begin : g_mask
         assign mask[i] = (32'(sel) > i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/tec_pin_sync.sv
module tec_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_async};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;
endmodule

// File: rtl/tec_count_core.sv
module tec_count_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         load_now,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] reload,
   output logic [W-1:0] count,
   output logic         ovf_pulse,
   output logic         div_out
);
   logic [W-1:0] cnt_q;
   logic         ovf_q;
   logic         div_q;
   logic         wrap;

   assign wrap = advance && (cnt_q == {W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         div_q <= 1'b0;
      end else begin
         ovf_q <= wrap;
         div_q <= div_q ^ wrap;
         if (load_now)     cnt_q <= load_val;
         else if (wrap)    cnt_q <= reload;
         else if (advance) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count     = cnt_q;
   assign ovf_pulse = ovf_q;
   assign div_out   = div_q;
endmodule

// File: rtl/tmr_evt_ctr.sv
module tmr_evt_ctr
   import tec_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PSC_SEL_W   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             ext_pin,
   output logic             irq,
   output logic             freq_out
);
   localparam int POL_BIT = PSC_SEL_W;
   localparam int EN_BIT  = PSC_SEL_W + 1;
   localparam int MODE_HI = CNT_W - 1;
   localparam int MODE_LO = CNT_W - 2;
   localparam logic [CNT_W-1:0] CTL_MASK =
      CNT_W'((1 << (PSC_SEL_W + 2)) - 1) | (CNT_W'(3) << MODE_LO);

   generate
      if (CNT_W < PSC_SEL_W + 4) begin : g_bad_width
         $error("CNT_W too narrow for the control fields");
      end
      if (PSC_SEL_W < 1) begin : g_bad_sel
         $error("PSC_SEL_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] ctl_q;
   logic [CNT_W-1:0] preload_q;
   logic [CNT_W-1:0] cnt_val;
   tec_mode_e        mode;
   logic             run, ctl_wr, pre_wr;
   logic             tick, pin_lvl, pin_rise, pin_fall;
   logic             gate_on, gate_end, pw_stop, advance;

   assign mode   = tec_mode_e'(ctl_q[MODE_HI:MODE_LO]);
   assign run    = ctl_q[EN_BIT] && (mode != MODE_OFF);
   assign ctl_wr = bus_wr && bus_addr;
   assign pre_wr = bus_wr && !bus_addr;

   tec_prescaler #(.SEL_W(PSC_SEL_W)) i_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl_wr),
      .sel     (ctl_q[PSC_SEL_W-1:0]),
      .tick    (tick)
   );

   tec_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_pin),
      .level     (pin_lvl),
      .rise      (pin_rise),
      .fall      (pin_fall)
   );

   assign gate_on  = ctl_q[POL_BIT] ? ~pin_lvl  : pin_lvl;
   assign gate_end = ctl_q[POL_BIT] ? pin_rise  : pin_fall;
   assign pw_stop  = run && (mode == MODE_PULSE) && gate_end;

   always_comb begin
      advance = 1'b0;
      if (run) begin
         unique case (mode)
            MODE_EVENT: advance = ctl_q[POL_BIT] ? pin_fall : pin_rise;
            MODE_TIMER: advance = tick;
            MODE_PULSE: advance = tick && gate_on;
            default:    advance = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         preload_q <= '0;
      end else begin
         if (pre_wr)       preload_q <= bus_wdata;
         if (ctl_wr)       ctl_q <= bus_wdata & CTL_MASK;
         else if (pw_stop) ctl_q[EN_BIT] <= 1'b0;
      end
   end

   tec_count_core #(.W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .load_now  (pre_wr && !run),
      .load_val  (bus_wdata),
      .reload    (preload_q),
      .count     (cnt_val),
      .ovf_pulse (irq),
      .div_out   (freq_out)
   );

   assign bus_rdata = bus_addr ? ctl_q : cnt_val;
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
   parameter int W       = 8,
   parameter int EN_BIT  = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_wr,
   input logic         bus_addr,
   input logic [W-1:0] ctl,
   input logic [W-1:0] preload,
   input logic [W-1:0] cnt,
   input logic         irq,
   input logic         freq_out
);
   logic         pre_wr, running;
   logic [W-1:0] cnt_inc;

   assign pre_wr  = bus_wr && !bus_addr;
   assign running = ctl[EN_BIT] && (ctl[W-1:W-2] != 2'b00);
   assign cnt_inc = cnt + 1'b1;

   AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(pre_wr)) |-> (cnt == preload)); // R7

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt != $past(cnt)) && !irq && !$past(pre_wr)) |-> (cnt == $past(cnt_inc))); // R4

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(running) && !$past(pre_wr)) |-> (cnt == $past(cnt))); // R9

   AST_FREQ_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      ((freq_out != $past(freq_out)) == irq)); // R8

   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && bus_addr) |-> (ctl[W-3] == 1'b0)); // R3
endmodule

bind tmr_evt_ctr tec_checker #(.W(CNT_W), .EN_BIT(PSC_SEL_W + 1)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .ctl      (ctl_q),
   .preload  (preload_q),
   .cnt      (cnt_val),
   .irq      (irq),
   .freq_out (freq_out)
);

// File: tb/test_tmr_evt_ctr.sv
module test_tmr_evt_ctr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ext_pin = 1'b0;
   logic       irq, freq_out;

   typedef struct {
      logic [7:0] v;
      string      tag;
   } item_t;

   item_t sb[$];
   int    vec = 0;
   int    bad = 0;
   int    irq_seen = 0;
   bit    done = 0;
   logic [7:0] m_cnt = 8'h00;
   logic [7:0] m_pre = 8'h00;
   int         m_ovf = 0;

   always #10 clk = ~clk;

   tmr_evt_ctr i_tmr_evt_ctr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
      .irq(irq), .freq_out(freq_out)
   );

   // monitor: pops expected reads and compares away from the active edge
   always @(negedge clk) begin
      if (rst_n && irq) irq_seen++;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         vec++;
         if (bus_rdata !== it.v) begin
            bad++;
            $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.v);
         end
      end
   end

   function automatic logic [7:0] ctl(input logic [1:0] md, input logic en,
                                      input logic pol, input logic [2:0] sel);
      return {md, 1'b0, en, pol, sel};
   endfunction

   function automatic void model_adv(input int n);
      for (int i = 0; i < n; i++) begin
         if (m_cnt == 8'hFF) begin
            m_cnt = m_pre;
            m_ovf++;
         end else m_cnt = m_cnt + 8'd1;
      end
   endfunction

   task automatic wr(input logic a, input logic [7:0] d);
      @(posedge clk); #2;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] e, input string tag);
      item_t it;
      @(posedge clk); #2;
      bus_addr = a;
      it.v = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic chk(input int got, input int exp, input string tag);
      vec++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run_timer(input logic [2:0] sel, input int n);
      wr(1'b1, ctl(2'b10, 1'b1, 1'b0, sel));
      repeat (n - 2) @(posedge clk);
      wr(1'b1, ctl(2'b10, 1'b0, 1'b0, sel));
      model_adv(n >> sel);
   endtask

   task automatic pin_set(input logic v, input int hold);
      @(posedge clk); #2;
      ext_pin = v;
      repeat (hold) @(posedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, 8'h00, "R1 counter");
      rd(1'b1, 8'h00, "R1 control");
      chk(irq, 0, "R1 irq");
      chk(freq_out, 0, "R1 freq_out");

      // R2 write while stopped loads counter
      wr(1'b0, 8'h5A); m_cnt = 8'h5A; m_pre = 8'h5A;
      rd(1'b0, 8'h5A, "R2 stopped load");

      // R9 mode 00 with enable set holds; R3 readback
      wr(1'b1, ctl(2'b00, 1'b1, 1'b0, 3'd0));
      repeat (20) @(posedge clk);
      rd(1'b0, 8'h5A, "R9 mode off holds");
      rd(1'b1, 8'h10, "R3 control readback");
      wr(1'b1, 8'hFF);
      rd(1'b1, 8'hDF, "R3 spare bit reads zero");

      // R4 timer with several prescaler ratios
      run_timer(3'd0, 10);
      rd(1'b0, m_cnt, "R4 divide 1");
      run_timer(3'd3, 40);
      rd(1'b0, m_cnt, "R4 divide 8");
      run_timer(3'd7, 300);
      rd(1'b0, m_cnt, "R4 divide 128");
      repeat (10) @(posedge clk);
      rd(1'b0, m_cnt, "R9 enable 0 holds");

      // R7/R8 overflow and reload
      wr(1'b0, 8'hF0); m_cnt = 8'hF0; m_pre = 8'hF0;
      run_timer(3'd0, 20);
      rd(1'b0, m_cnt, "R7 reload after wrap");
      chk(irq_seen, m_ovf, "R7 irq count");
      chk(freq_out, m_ovf % 2, "R8 freq_out parity");
      wr(1'b0, 8'hFE); m_cnt = 8'hFE; m_pre = 8'hFE;
      run_timer(3'd0, 4);
      rd(1'b0, m_cnt, "R7 back-to-back wrap");
      chk(irq_seen, m_ovf, "R7 irq count 2");
      chk(freq_out, m_ovf % 2, "R8 freq_out parity 2");

      // R5 event rising; R2 write while running leaves counter
      wr(1'b1, ctl(2'b01, 1'b1, 1'b0, 3'd0));
      wr(1'b0, 8'h33); m_pre = 8'h33;
      rd(1'b0, m_cnt, "R2 running write keeps counter");
      pin_set(1'b1, 6); pin_set(1'b0, 6);
      pin_set(1'b1, 6); pin_set(1'b0, 6);
      model_adv(2);
      rd(1'b0, m_cnt, "R5 rising edges counted");
      chk(irq_seen, m_ovf, "R7 irq from event wrap");

      // R5 falling polarity
      wr(1'b1, ctl(2'b01, 1'b1, 1'b1, 3'd0));
      pin_set(1'b1, 6);
      rd(1'b0, m_cnt, "R5 rise ignored when falling selected");
      pin_set(1'b0, 6);
      model_adv(1);
      rd(1'b0, m_cnt, "R5 falling edge counted");

      // R6 pulse width, active high
      wr(1'b1, ctl(2'b11, 1'b1, 1'b0, 3'd0));
      repeat (8) @(posedge clk);
      rd(1'b0, m_cnt, "R6 inactive level no count");
      pin_set(1'b1, 7);
      #2 ext_pin = 1'b0;
      repeat (5) @(posedge clk);
      model_adv(7);
      rd(1'b0, m_cnt, "R6 high width counted");
      rd(1'b1, ctl(2'b11, 1'b0, 1'b0, 3'd0), "R6 enable auto-cleared");
      pin_set(1'b1, 6); pin_set(1'b0, 6);
      rd(1'b0, m_cnt, "R6 stopped after gate end");

      // R6 pulse width, active low, divide 2
      pin_set(1'b1, 4);
      wr(1'b1, ctl(2'b11, 1'b1, 1'b1, 3'd1));
      repeat (4) @(posedge clk);
      pin_set(1'b0, 10);
      #2 ext_pin = 1'b1;
      repeat (6) @(posedge clk);
      model_adv(5);
      rd(1'b0, m_cnt, "R6 low width divide 2");
      rd(1'b1, ctl(2'b11, 1'b0, 1'b1, 3'd1), "R6 enable auto-cleared low");

      repeat (3) @(posedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule